// File: doc/BRIEF.md
# Short-Command SPI Engine

This block is an SPI master for short flash commands, driven by a host through eight byte-wide registers. The host first fills in an opcode, up to three address bytes and one trailing data byte. It then writes a control byte. That byte picks the SCK rate, how many bytes go out (1, 2, 4 or 5) and how many response bytes come back (0 to 3). The engine then lowers chip select and shifts the selected bytes out in SPI mode 0, most significant bit first. It clocks in the requested response bytes and stores them in registers the host can read. Status bit 7 shows that a transfer is running.

Both SCK rates come from the system clock through two half-period divider parameters, one for the fast rate and one for the slow rate. The defaults suit a 200 MHz system clock: 6 clocks per SCK period gives about 33 MHz, and 12 clocks gives about 16 MHz. Memory-mapped reads and streaming page programming are not handled here.

Top module: `spi_cmd_engine`

## Requirements
- R1: After reset, a status read at offset 0 returns 0x00, spi_cs_n is high, spi_sck is low, and offsets 1 to 7 read 0x00.
- R2: A control write at offset 0 starts a transfer only when bits 7:4 are 4 (slow rate) or 5 (fast rate). Any other value leaves spi_cs_n high and status at 0x00.
- R3: Control bits 1:0 select the output length: code 0 sends 1 byte, code 1 sends 2, code 2 sends 4 and code 3 sends 5. The opcode at offset 1 always goes first. For codes 2 and 3 the address follows in the order offset 4, offset 3, offset 2. The byte at offset 7 goes last for codes 1 and 3.
- R4: Control bits 3:2 give the number of response bytes, 0 to 3. These bytes are clocked in after all output bytes and are stored at offsets 5, 6 and 7 in the order they arrive. Any offset not written by the response keeps its earlier value.
- R5: The SPI interface uses mode 0. SCK is low whenever chip select is high. MOSI changes only while SCK is low. Each byte goes out most significant bit first. Chip select stays low for the whole transfer.
- R6: The SCK period is 2*FAST_HALF system clocks at the fast rate and 2*SLOW_HALF at the slow rate. The first rising SCK edge comes one half period after chip select falls.
- R7: spi_cs_n rises exactly one SCK period (two half periods) after the last falling SCK edge.
- R8: Status bit 7 reads 1 from the clock edge that accepts the control write. It clears one clock after spi_cs_n rises. From then on, the response registers hold the received bytes.
- R9: While a transfer is running, writes to any offset are ignored. This includes a new control write, which neither starts a second transfer nor changes the current one.
- R10: When idle, offsets 1 to 7 read back the last value written. Status bits 6:0 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| host_wr | input | 1 | Host write strobe, sampled on the rising clock edge |
| host_addr | input | 3 | Register offset within the 8-byte window |
| host_wdata | input | 8 | Host write data |
| host_rdata | output | 8 | Read data for host_addr (combinational) |
| spi_sck | output | 1 | SPI serial clock, idle low |
| spi_mosi | output | 1 | Serial data from the engine to the flash |
| spi_miso | input | 1 | Serial data from the flash to the engine |
| spi_cs_n | output | 1 | Active-low chip select |

## Verification
The hardest cases to reach from the ports are the ones that overlap an active transfer: a second control write or a register write that lands while chip select is low, and the response write into offset 7, which shares a register with the trailing output byte. The bench starts a slow transfer and then issues writes while it is still running. It then checks three things: the wire carried only the original bytes, exactly one chip-select pulse occurred, and the opcode register still reads its old value. A bench-side flash model places response bytes right after the output bytes for every length code. This shows that offset 7 is overwritten only when three bytes are read.

// File: rtl/spi_cmd_pkg.sv
package spi_cmd_pkg;

    localparam int REG_COUNT = 8;
    localparam int ADDR_W    = $clog2(REG_COUNT);
    localparam int MAX_SEND  = 5;
    localparam int MAX_READ  = 3;
    localparam int MAX_BITS  = (MAX_SEND + MAX_READ) * 8;
    localparam int BIT_CNT_W = $clog2(MAX_BITS + 1);
    localparam int FRAME_W   = MAX_SEND * 8;

    // register offsets inside the host window
    localparam logic [ADDR_W-1:0] OFS_CTRL    = 3'd0;
    localparam logic [ADDR_W-1:0] OFS_OPC     = 3'd1;
    localparam logic [ADDR_W-1:0] OFS_ADR_LO  = 3'd2;
    localparam logic [ADDR_W-1:0] OFS_ADR_MID = 3'd3;
    localparam logic [ADDR_W-1:0] OFS_ADR_HI  = 3'd4;
    localparam logic [ADDR_W-1:0] OFS_RSP0    = 3'd5;
    localparam logic [ADDR_W-1:0] OFS_TRAIL   = 3'd7;

    localparam logic [3:0] RATE_SLOW = 4'h4;
    localparam logic [3:0] RATE_FAST = 4'h5;

    typedef struct packed {
        logic [3:0] rate;
        logic [1:0] rd_cnt;
        logic [1:0] len_code;
    } ctrl_t;

    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_SHIFT,
        SEQ_TAIL,
        SEQ_RELEASE
    } seq_state_t;

    typedef struct packed {
        logic [7:0] opc;
        logic [7:0] adr_hi;
        logic [7:0] adr_mid;
        logic [7:0] adr_lo;
        logic [7:0] trail;
    } cmd_bytes_t;

    function automatic logic [2:0] send_len(logic [1:0] code);
        case (code)
            2'd0:    return 3'd1;
            2'd1:    return 3'd2;
            2'd2:    return 3'd4;
            default: return 3'd5;
        endcase
    endfunction

    function automatic logic ctrl_ok(ctrl_t c);
        return (c.rate == RATE_SLOW) || (c.rate == RATE_FAST);
    endfunction

    // left-aligned output frame, first wire bit at the top
    function automatic logic [FRAME_W-1:0] pack_frame(logic [1:0] code, cmd_bytes_t b);
        case (code)
            2'd0:    return {b.opc, 32'h0};
            2'd1:    return {b.opc, b.trail, 24'h0};
            2'd2:    return {b.opc, b.adr_hi, b.adr_mid, b.adr_lo, 8'h0};
            default: return {b.opc, b.adr_hi, b.adr_mid, b.adr_lo, b.trail};
        endcase
    endfunction

endpackage

// File: rtl/spi_cmd_regs.sv
module spi_cmd_regs
    import spi_cmd_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [7:0]        wdata,
    input  logic              busy,
    input  logic              cap_we,
    input  logic [1:0]        cap_idx,
    input  logic [7:0]        cap_byte,
    output logic [7:0]        rdata,
    output cmd_bytes_t        cmd
);

    logic [7:0] bank [REG_COUNT];
    logic [ADDR_W-1:0] cap_ofs;

    assign cap_ofs = OFS_RSP0 + ADDR_W'(cap_idx);

    generate
        for (genvar g = 0; g < REG_COUNT; g++) begin : g_byte
            if (g == 0) begin : g_status_slot
                always_ff @(posedge clk) bank[g] <= 8'h00;
            end else begin : g_data_slot
                always_ff @(posedge clk) begin
                    if (rst) begin
                        bank[g] <= 8'h00;
                    end else if (cap_we && cap_ofs == ADDR_W'(g)) begin
                        bank[g] <= cap_byte;
                    end else if (wr_en && !busy && addr == ADDR_W'(g)) begin
                        bank[g] <= wdata;
                    end
                end
            end
        end
    endgenerate

    always_comb begin
        rdata = bank[addr];
        if (addr == OFS_CTRL) rdata = {busy, 7'b0};
    end

    assign cmd.opc     = bank[OFS_OPC];
    assign cmd.adr_hi  = bank[OFS_ADR_HI];
    assign cmd.adr_mid = bank[OFS_ADR_MID];
    assign cmd.adr_lo  = bank[OFS_ADR_LO];
    assign cmd.trail   = bank[OFS_TRAIL];

    // R4: response capture only happens inside a transfer
    a_r4_capture_in_transfer: assert property (@(posedge clk) disable iff (rst)
        cap_we |-> busy);

    // R9: a busy-time host write leaves the opcode untouched
    a_r9_opcode_frozen: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(cmd.opc));

endmodule

// File: rtl/spi_cmd_clkdiv.sv
module spi_cmd_clkdiv #(
    parameter int FAST_HALF = 3,
    parameter int SLOW_HALF = 6
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    input  logic fast,
    output logic tick
);

    localparam int MAX_HALF = (FAST_HALF > SLOW_HALF) ? FAST_HALF : SLOW_HALF;
    localparam int CNT_W    = (MAX_HALF > 1) ? $clog2(MAX_HALF) : 1;

    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] lim;

    assign lim  = fast ? CNT_W'(FAST_HALF - 1) : CNT_W'(SLOW_HALF - 1);
    assign tick = run && (cnt == lim);

    always_ff @(posedge clk) begin
        if (rst || !run || tick) cnt <= '0;
        else                     cnt <= cnt + 1'b1;
    end

    // R6: the half-period counter never passes its limit
    a_r6_count_bound: assert property (@(posedge clk) disable iff (rst)
        run |-> (cnt <= lim));

endmodule

// File: rtl/spi_cmd_seq.sv
module spi_cmd_seq
    import spi_cmd_pkg::*;
(
    input  logic               clk,
    input  logic               rst,
    input  logic               start,
    input  ctrl_t              ctrl,
    input  logic [FRAME_W-1:0] frame,
    input  logic               tick,
    input  logic               miso,
    output logic               busy,
    output logic               run,
    output logic               fast,
    output logic               sck,
    output logic               mosi,
    output logic               cs_n,
    output logic               cap_we,
    output logic [1:0]         cap_idx,
    output logic [7:0]         cap_byte
);

    seq_state_t           state;
    logic [FRAME_W-1:0]   tx_sh;
    logic [BIT_CNT_W-1:0] bit_cnt;
    logic [BIT_CNT_W-1:0] total_bits;
    logic [BIT_CNT_W-1:0] tx_bits;
    logic [7:0]           rx_sh;
    logic [1:0]           rx_idx;
    logic                 tail_half;
    logic [3:0]           nbytes;

    assign nbytes = {1'b0, send_len(ctrl.len_code)} + {2'b0, ctrl.rd_cnt};
    assign run    = (state == SEQ_SHIFT) || (state == SEQ_TAIL);

    always_ff @(posedge clk) begin
        if (rst) begin
            state      <= SEQ_IDLE;
            busy       <= 1'b0;
            fast       <= 1'b0;
            sck        <= 1'b0;
            mosi       <= 1'b0;
            cs_n       <= 1'b1;
            tx_sh      <= '0;
            bit_cnt    <= '0;
            total_bits <= '0;
            tx_bits    <= '0;
            rx_sh      <= '0;
            rx_idx     <= '0;
            tail_half  <= 1'b0;
            cap_we     <= 1'b0;
            cap_idx    <= '0;
            cap_byte   <= '0;
        end else begin
            cap_we <= 1'b0;
            case (state)
                SEQ_IDLE: begin
                    if (start) begin
                        state      <= SEQ_SHIFT;
                        busy       <= 1'b1;
                        cs_n       <= 1'b0;
                        sck        <= 1'b0;
                        fast       <= (ctrl.rate == RATE_FAST);
                        tx_sh      <= frame;
                        mosi       <= frame[FRAME_W-1];
                        bit_cnt    <= '0;
                        total_bits <= {nbytes, 3'b000};
                        tx_bits    <= {1'b0, send_len(ctrl.len_code), 3'b000};
                        rx_idx     <= '0;
                        tail_half  <= 1'b0;
                    end
                end
                SEQ_SHIFT: begin
                    if (tick) begin
                        if (!sck) begin
                            sck <= 1'b1;
                            if (bit_cnt >= tx_bits) begin
                                rx_sh <= {rx_sh[6:0], miso};
                                if (bit_cnt[2:0] == 3'd7) begin
                                    cap_we   <= 1'b1;
                                    cap_idx  <= rx_idx;
                                    cap_byte <= {rx_sh[6:0], miso};
                                    rx_idx   <= rx_idx + 1'b1;
                                end
                            end
                        end else begin
                            sck     <= 1'b0;
                            bit_cnt <= bit_cnt + 1'b1;
                            if (bit_cnt + 1'b1 == total_bits) begin
                                state <= SEQ_TAIL;
                                mosi  <= 1'b0;
                            end else begin
                                tx_sh <= {tx_sh[FRAME_W-2:0], 1'b0};
                                mosi  <= tx_sh[FRAME_W-2];
                            end
                        end
                    end
                end
                SEQ_TAIL: begin
                    if (tick) begin
                        if (tail_half) begin
                            cs_n  <= 1'b1;
                            state <= SEQ_RELEASE;
                        end else begin
                            tail_half <= 1'b1;
                        end
                    end
                end
                default: begin
                    busy  <= 1'b0;
                    state <= SEQ_IDLE;
                end
            endcase
        end
    end

    // R5: chip select low only inside a busy window
    a_r5_cs_within_busy: assert property (@(posedge clk) disable iff (rst)
        !cs_n |-> busy);

    // R5: clock idles low while deselected
    a_r5_sck_idle_low: assert property (@(posedge clk) disable iff (rst)
        cs_n |-> !sck);

    // R5: data holds while the clock is high
    a_r5_mosi_hold_high: assert property (@(posedge clk) disable iff (rst)
        (sck && $past(sck)) |-> $stable(mosi));

    // R7: chip select releases only out of the tail wait
    a_r7_release_from_tail: assert property (@(posedge clk) disable iff (rst)
        $rose(cs_n) |-> ($past(state) == SEQ_TAIL));

    // R8: busy drops only after chip select is already high
    a_r8_busy_after_cs: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> $past(cs_n));

    // R9: transfer length is not reloaded mid-transfer
    a_r9_no_reload: assert property (@(posedge clk) disable iff (rst)
        (state != SEQ_IDLE) |=> $stable(total_bits));

endmodule

// File: rtl/spi_cmd_engine.sv
module spi_cmd_engine
    import spi_cmd_pkg::*;
#(
    parameter int FAST_HALF = 3,
    parameter int SLOW_HALF = 6
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_wr,
    input  logic [2:0] host_addr,
    input  logic [7:0] host_wdata,
    output logic [7:0] host_rdata,
    output logic       spi_sck,
    output logic       spi_mosi,
    input  logic       spi_miso,
    output logic       spi_cs_n
);

    ctrl_t              ctrl_in;
    cmd_bytes_t         cmd;
    logic [FRAME_W-1:0] frame;
    logic               busy;
    logic               start;
    logic               run;
    logic               fast;
    logic               tick;
    logic               cap_we;
    logic [1:0]         cap_idx;
    logic [7:0]         cap_byte;

    assign ctrl_in = ctrl_t'(host_wdata);
    assign frame   = pack_frame(ctrl_in.len_code, cmd);
    assign start   = host_wr && (host_addr == OFS_CTRL) && !busy && ctrl_ok(ctrl_in);

    spi_cmd_regs u_regs (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (host_wr),
        .addr     (host_addr),
        .wdata    (host_wdata),
        .busy     (busy),
        .cap_we   (cap_we),
        .cap_idx  (cap_idx),
        .cap_byte (cap_byte),
        .rdata    (host_rdata),
        .cmd      (cmd)
    );

    spi_cmd_clkdiv #(
        .FAST_HALF (FAST_HALF),
        .SLOW_HALF (SLOW_HALF)
    ) u_div (
        .clk  (clk),
        .rst  (rst),
        .run  (run),
        .fast (fast),
        .tick (tick)
    );

    spi_cmd_seq u_seq (
        .clk      (clk),
        .rst      (rst),
        .start    (start),
        .ctrl     (ctrl_in),
        .frame    (frame),
        .tick     (tick),
        .miso     (spi_miso),
        .busy     (busy),
        .run      (run),
        .fast     (fast),
        .sck      (spi_sck),
        .mosi     (spi_mosi),
        .cs_n     (spi_cs_n),
        .cap_we   (cap_we),
        .cap_idx  (cap_idx),
        .cap_byte (cap_byte)
    );

    // R2: an unsupported rate nibble never raises busy
    a_r2_bad_rate_idle: assert property (@(posedge clk) disable iff (rst)
        (host_wr && host_addr == OFS_CTRL && !busy && !ctrl_ok(ctrl_in)) |=> !busy);

    // R8: an accepted control write shows busy on the next cycle
    a_r8_busy_follows_start: assert property (@(posedge clk) disable iff (rst)
        start |=> (busy && !spi_cs_n));

endmodule

// File: tb/tb_spi_cmd_engine.sv
`timescale 1ns/1ps
module tb_spi_cmd_engine;

    localparam int FAST_H = 3;
    localparam int SLOW_H = 6;
    localparam int NVEC   = 7;
    // {ctrl, opcode, ofs4, ofs3, ofs2, ofs7, rsp0, rsp1, rsp2}
    localparam logic [71:0] VECS [NVEC] = '{
        72'h40_06_00_00_00_00_11_22_33,
        72'h5D_9F_00_00_00_3C_C2_20_16,
        72'h52_20_12_34_56_00_44_55_66,
        72'h47_02_AB_CD_EF_7E_81_00_00,
        72'h5B_0B_01_02_03_99_F0_0F_00,
        72'h49_05_00_00_00_71_E7_18_00,
        72'h4E_03_80_40_20_AA_DE_AD_BE
    };

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       host_wr = 1'b0;
    logic [2:0] host_addr = 3'd0;
    logic [7:0] host_wdata = 8'h00;
    logic [7:0] host_rdata;
    logic       spi_sck, spi_mosi, spi_cs_n;
    logic       spi_miso = 1'b0;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    spi_cmd_engine #(.FAST_HALF(FAST_H), .SLOW_HALF(SLOW_H)) dut (
        .clk(clk), .rst(rst), .host_wr(host_wr), .host_addr(host_addr),
        .host_wdata(host_wdata), .host_rdata(host_rdata), .spi_sck(spi_sck),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .spi_cs_n(spi_cs_n)
    );

    // flash model and wire monitor, sampled between clock edges
    int cyc = 0, cs_fall_cyc = 0, first_rise = 0, last_rise = 0, last_fall = 0;
    int cs_rise_cyc = 0, nbits = 0, period_bad = 0, mode_bad = 0, exp_period = 12;
    int n_cs_fall = 0, n_cs_rise = 0;
    logic [63:0] mosi_cap = '0, sl_sh = '0, mstream = '0;
    logic prev_cs = 1'b1, prev_sck = 1'b0, prev_mosi = 1'b0;

    always @(negedge clk) begin
        cyc++;
        if (prev_cs && !spi_cs_n) begin
            n_cs_fall++; cs_fall_cyc = cyc; sl_sh = mstream; spi_miso = sl_sh[63];
            nbits = 0; mosi_cap = '0; period_bad = 0; mode_bad = 0;
        end
        if (!prev_sck && spi_sck) begin
            if (nbits == 0) first_rise = cyc;
            else if (cyc - last_rise != exp_period) period_bad++;
            last_rise = cyc; mosi_cap = {mosi_cap[62:0], spi_mosi}; nbits++;
        end
        if (prev_sck && !spi_sck) begin
            last_fall = cyc; sl_sh = {sl_sh[62:0], 1'b0}; spi_miso = sl_sh[63];
        end
        if (prev_sck && spi_sck && spi_mosi !== prev_mosi) mode_bad++;
        if (spi_cs_n && spi_sck) mode_bad++;
        if (!prev_cs && spi_cs_n) begin cs_rise_cyc = cyc; n_cs_rise++; end
        prev_cs = spi_cs_n; prev_sck = spi_sck; prev_mosi = spi_mosi;
    end

    task automatic check(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk); #1;
    endtask

    task automatic host_write(input logic [2:0] a, input logic [7:0] d);
        step();
        host_addr = a; host_wdata = d; host_wr = 1'b1;
        step();
        host_wr = 1'b0;
    endtask

    task automatic host_read(input logic [2:0] a, output logic [7:0] d);
        host_addr = a; #0.5; d = host_rdata;
    endtask

    task automatic wait_release(input string tag, input int rises_before);
        int guard = 0;
        logic [7:0] st;
        while (n_cs_rise == rises_before && guard < 5000) begin step(); guard++; end
        check(guard < 5000, {tag, " R8 transfer completes"}, guard, 0);
        host_read(3'd0, st);
        check(st == 8'h80, {tag, " R8 busy still set on CS rise cycle"}, st, 8'h80);
        step();
        host_read(3'd0, st);
        check(st == 8'h00, {tag, " R8 busy clear one clock later"}, st, 8'h00);
    endtask

    task automatic run_vec(input logic [71:0] v, input string tag);
        logic [7:0] ctl, op, a4, a3, a2, tl, r0, r1, r2, st, rd;
        int nsend, nrd, half, rises;
        logic [63:0] exp_tx, got_tx, mask;
        {ctl, op, a4, a3, a2, tl, r0, r1, r2} = v;
        nrd = int'(ctl[3:2]);
        case (ctl[1:0])
            2'd0: begin nsend = 1; exp_tx = {56'h0, op}; end
            2'd1: begin nsend = 2; exp_tx = {48'h0, op, tl}; end
            2'd2: begin nsend = 4; exp_tx = {32'h0, op, a4, a3, a2}; end
            default: begin nsend = 5; exp_tx = {24'h0, op, a4, a3, a2, tl}; end
        endcase
        half = (ctl[7:4] == 4'h5) ? FAST_H : SLOW_H;
        exp_period = 2 * half;
        mstream = {r0, r1, r2, 40'h0} >> (nsend * 8);
        host_write(3'd1, op); host_write(3'd2, a2); host_write(3'd3, a3);
        host_write(3'd4, a4); host_write(3'd7, tl);
        host_write(3'd5, 8'hA5); host_write(3'd6, 8'h5A);
        rises = n_cs_rise;
        host_write(3'd0, ctl);
        host_read(3'd0, st);
        check(st == 8'h80 && spi_cs_n == 1'b0, {tag, " R8 busy right after control write"}, {spi_cs_n, st}, 9'h080);
        wait_release(tag, rises);
        check(nbits == (nsend + nrd) * 8, {tag, " R3 R4 total SCK pulses"}, nbits, (nsend + nrd) * 8);
        mask = (64'h1 << (nsend * 8)) - 1;
        got_tx = (mosi_cap >> (nrd * 8)) & mask;
        check(got_tx == exp_tx, {tag, " R3 wire byte order"}, got_tx, exp_tx);
        check(mode_bad == 0, {tag, " R5 mode 0 MOSI/SCK discipline"}, mode_bad, 0);
        check(period_bad == 0 && first_rise - cs_fall_cyc == half, {tag, " R6 SCK period and lead"},
              first_rise - cs_fall_cyc, half);
        check(cs_rise_cyc - last_fall == 2 * half, {tag, " R7 CS release delay"}, cs_rise_cyc - last_fall, 2 * half);
        host_read(3'd5, rd);
        check(rd == ((nrd >= 1) ? r0 : 8'hA5), {tag, " R4 offset 5"}, rd, (nrd >= 1) ? r0 : 8'hA5);
        host_read(3'd6, rd);
        check(rd == ((nrd >= 2) ? r1 : 8'h5A), {tag, " R4 offset 6"}, rd, (nrd >= 2) ? r1 : 8'h5A);
        host_read(3'd7, rd);
        check(rd == ((nrd == 3) ? r2 : tl), {tag, " R4 offset 7"}, rd, (nrd == 3) ? r2 : tl);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog R8 actual=hung expected=finished");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    initial begin
        logic [7:0] rd;
        int falls;
        repeat (4) step();
        rst = 1'b0;
        step();
        // R1 reset state
        host_read(3'd0, rd);
        check(rd == 8'h00, "R1 status after reset", rd, 0);
        check(spi_cs_n == 1'b1 && spi_sck == 1'b0, "R1 pins idle after reset", {spi_cs_n, spi_sck}, 2'b10);
        host_read(3'd1, rd);
        check(rd == 8'h00, "R1 opcode register after reset", rd, 0);
        // R10 plain register readback
        host_write(3'd3, 8'h5A);
        host_read(3'd3, rd);
        check(rd == 8'h5A, "R10 readback offset 3", rd, 8'h5A);
        host_read(3'd0, rd);
        check(rd[6:0] == 7'h0, "R10 status low bits zero", rd, 0);
        // vector table
        for (int i = 0; i < NVEC; i++) run_vec(VECS[i], $sformatf("vec%0d", i));
        // R2 invalid rate nibbles
        falls = n_cs_fall;
        host_write(3'd0, 8'h35);
        host_write(3'd0, 8'h65);
        host_write(3'd0, 8'h00);
        repeat (30) step();
        host_read(3'd0, rd);
        check(rd == 8'h00, "R2 bad rate leaves status idle", rd, 0);
        check(n_cs_fall == falls, "R2 bad rate keeps CS high", n_cs_fall - falls, 0);
        // R9 writes during a running transfer
        begin
            int rises;
            mstream = '0;
            exp_period = 2 * SLOW_H;
            host_write(3'd1, 8'hD8); host_write(3'd4, 8'h01);
            host_write(3'd3, 8'h02); host_write(3'd2, 8'h03);
            falls = n_cs_fall;
            rises = n_cs_rise;
            host_write(3'd0, 8'h42);
            host_write(3'd0, 8'h5F);
            host_write(3'd1, 8'hEE);
            wait_release("busywr", rises);
            check(nbits == 32, "R9 transfer length unchanged", nbits, 32);
            check(mosi_cap[31:0] == 32'hD8010203, "R9 wire bytes unchanged", mosi_cap[31:0], 32'hD8010203);
            host_read(3'd1, rd);
            check(rd == 8'hD8, "R9 opcode write ignored while busy", rd, 8'hD8);
            repeat (40) step();
            check(n_cs_fall - falls == 1, "R9 no second transfer", n_cs_fall - falls, 1);
        end
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

endmodule